// File: doc/BRIEF.md
# Multi-Channel Serial FIFO Event Flagger

This block watches the pointer pairs of four serial channels, each with a receive FIFO and a transmit FIFO, and turns two FIFO conditions into a per-channel event flag. The first condition is receive data waiting, meaning the receive read and write pointers differ. The second is transmit drained, meaning the transmit read and write pointers are equal. A condition is reported only once for a given pointer position, not on every evaluation while it lasts.

For each channel and each direction the block records the pointer value at which it last reported. The value 0xFF in that record means "no record". A condition reports again only when the relevant pointer moves to a value different from the record. Evaluation happens on the cycles where the evaluate strobe is high. The flags then stay set until software-side logic clears them through a write-one-to-clear mask.

The FIFO storage and the serial line logic sit outside this block. The block only reads their pointers.

Top module: `fifo_irq_flagger`

## Requirements
- R1: After reset, `irqFlags` is 0 and both `lastRxPtrs` and `lastTxPtrs` are 32'hFFFF_FFFF.
- R2: Channel n uses byte [8n+7:8n] of every packed pointer bus and bit n of `irqFlags`. Every state change becomes visible on the outputs one clock after the edge that samples `evalStrobe` high.
- R3: On an evaluation where a channel's receive read and write pointers are equal, no receive event is raised for that channel and its last-RX byte becomes 0xFF.
- R4: On an evaluation where the receive pointers differ and the receive read pointer equals the stored last-RX byte, no receive event is raised and the byte keeps its value.
- R5: On an evaluation where the receive pointers differ and the receive read pointer differs from the stored last-RX byte, the channel flag is set and the last-RX byte takes the read pointer.
- R6: On an evaluation where a channel's transmit read and write pointers differ, no transmit event is raised and its last-TX byte becomes 0xFF.
- R7: On an evaluation where the transmit pointers are equal, the flag is set and the last-TX byte takes the write pointer if the write pointer differs from that byte. If they are equal, nothing is raised and the byte holds.
- R8: Receive and transmit events of one channel in the same evaluation set the single flag bit of that channel.
- R9: Flags are sticky. A 1 in bit n of `clearFlags` clears flag n on any cycle. An event raised on the same cycle overrides the clear.
- R10: A receive read pointer of 0xFF, with receive non-empty, raises nothing while the stored byte holds the sentinel 0xFF.
- R11: On cycles with `evalStrobe` low, both packed pointer records hold and no flag is set, whatever the pointers do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evalStrobe | input | 1 | Evaluate all channels on this cycle |
| rxRdPtr | input | 32 | Receive read pointers, one byte per channel |
| rxWrPtr | input | 32 | Receive write pointers, one byte per channel |
| txRdPtr | input | 32 | Transmit read pointers, one byte per channel |
| txWrPtr | input | 32 | Transmit write pointers, one byte per channel |
| clearFlags | input | 4 | Write-one-to-clear mask for the flags |
| irqFlags | output | 4 | Sticky per-channel event flags |
| lastRxPtrs | output | 32 | Stored last-reported receive read pointers |
| lastTxPtrs | output | 32 | Stored last-reported transmit write pointers |

## Verification
The bench repeats an evaluation with unchanged pointers. A design that treated the condition as a level would set the flag again right after it was cleared. The bench also drives a receive read pointer of 0xFF against the sentinel. A design that compared against a separate valid bit instead of the stored byte would raise an event there. It fires an event on the same cycle as a clear of that bit, and a design that gave the clear priority would lose the event. Finally, it moves pointers on non-strobe cycles, and a design that evaluated continuously would change its records or flags.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int NUM_CH = 4;
  localparam int PTR_W  = 8;
  localparam int BUS_W  = NUM_CH * PTR_W;

  typedef struct packed {
    logic              evalEn;
    logic [NUM_CH-1:0] clrMask;
  } ctrlStrobes_t;
endpackage

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
(
  input  logic              evalStrobe,
  input  logic [NUM_CH-1:0] clearFlags,
  output ctrlStrobes_t      strobes
);
  always_comb begin
    strobes.evalEn  = evalStrobe;
    strobes.clrMask = clearFlags;
  end
endmodule

// File: rtl/fifo_irq_datapath.sv
module fifo_irq_datapath
  import fifo_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [BUS_W-1:0]  rxRdPtr,
  input  logic [BUS_W-1:0]  rxWrPtr,
  input  logic [BUS_W-1:0]  txRdPtr,
  input  logic [BUS_W-1:0]  txWrPtr,
  output logic [NUM_CH-1:0] irqFlags,
  output logic [BUS_W-1:0]  lastRxPtrs,
  output logic [BUS_W-1:0]  lastTxPtrs
);
  localparam logic [PTR_W-1:0] NO_RECORD = '1;

  logic [NUM_CH-1:0] chFire;
  logic [BUS_W-1:0]  nextRx;
  logic [BUS_W-1:0]  nextTx;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [PTR_W-1:0] rxRd, rxWr, txRd, txWr, prevRx, prevTx;
    logic             rxFire, txFire;

    assign rxRd   = rxRdPtr[ch*PTR_W +: PTR_W];
    assign rxWr   = rxWrPtr[ch*PTR_W +: PTR_W];
    assign txRd   = txRdPtr[ch*PTR_W +: PTR_W];
    assign txWr   = txWrPtr[ch*PTR_W +: PTR_W];
    assign prevRx = lastRxPtrs[ch*PTR_W +: PTR_W];
    assign prevTx = lastTxPtrs[ch*PTR_W +: PTR_W];

    // receive side: data waiting, reported once per read position
    always_comb begin
      rxFire = 1'b0;
      nextRx[ch*PTR_W +: PTR_W] = prevRx;
      if (rxRd == rxWr) begin
        nextRx[ch*PTR_W +: PTR_W] = NO_RECORD;
      end else if (rxRd != prevRx) begin
        rxFire = 1'b1;
        nextRx[ch*PTR_W +: PTR_W] = rxRd;
      end
    end

    // transmit side: drained, reported once per write position
    always_comb begin
      txFire = 1'b0;
      nextTx[ch*PTR_W +: PTR_W] = prevTx;
      if (txRd != txWr) begin
        nextTx[ch*PTR_W +: PTR_W] = NO_RECORD;
      end else if (txWr != prevTx) begin
        txFire = 1'b1;
        nextTx[ch*PTR_W +: PTR_W] = txWr;
      end
    end

    assign chFire[ch] = strobes.evalEn & (rxFire | txFire);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlags   <= '0;
      lastRxPtrs <= '1;
      lastTxPtrs <= '1;
    end else begin
      irqFlags <= (irqFlags & ~strobes.clrMask) | chFire;
      if (strobes.evalEn) begin
        lastRxPtrs <= nextRx;
        lastTxPtrs <= nextTx;
      end
    end
  end
endmodule

// File: rtl/fifo_irq_flagger.sv
module fifo_irq_flagger
  import fifo_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalStrobe,
  input  logic [BUS_W-1:0]  rxRdPtr,
  input  logic [BUS_W-1:0]  rxWrPtr,
  input  logic [BUS_W-1:0]  txRdPtr,
  input  logic [BUS_W-1:0]  txWrPtr,
  input  logic [NUM_CH-1:0] clearFlags,
  output logic [NUM_CH-1:0] irqFlags,
  output logic [BUS_W-1:0]  lastRxPtrs,
  output logic [BUS_W-1:0]  lastTxPtrs
);
  ctrlStrobes_t strobes;

  fifo_irq_ctrl ctrl_i (
    .evalStrobe (evalStrobe),
    .clearFlags (clearFlags),
    .strobes    (strobes)
  );

  fifo_irq_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .rxRdPtr    (rxRdPtr),
    .rxWrPtr    (rxWrPtr),
    .txRdPtr    (txRdPtr),
    .txWrPtr    (txWrPtr),
    .irqFlags   (irqFlags),
    .lastRxPtrs (lastRxPtrs),
    .lastTxPtrs (lastTxPtrs)
  );
endmodule

// File: rtl/fifo_irq_checker.sv
module fifo_irq_checker
  import fifo_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              evalStrobe,
  input logic [BUS_W-1:0]  rxRdPtr,
  input logic [BUS_W-1:0]  rxWrPtr,
  input logic [BUS_W-1:0]  txRdPtr,
  input logic [BUS_W-1:0]  txWrPtr,
  input logic [NUM_CH-1:0] clearFlags,
  input logic [NUM_CH-1:0] irqFlags,
  input logic [BUS_W-1:0]  lastRxPtrs,
  input logic [BUS_W-1:0]  lastTxPtrs
);
  p_hold_no_eval_r11: assert property (@(posedge clk) disable iff (!rstN)
    !evalStrobe |=> $stable(lastRxPtrs) && $stable(lastTxPtrs));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!evalStrobe && clearFlags == '0) |=> $stable(irqFlags));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    p_rx_empty_r3: assert property (@(posedge clk) disable iff (!rstN)
      (evalStrobe && rxRdPtr[ch*PTR_W +: PTR_W] == rxWrPtr[ch*PTR_W +: PTR_W])
      |=> lastRxPtrs[ch*PTR_W +: PTR_W] == 8'hFF);

    p_rx_fire_r5: assert property (@(posedge clk) disable iff (!rstN)
      (evalStrobe && rxRdPtr[ch*PTR_W +: PTR_W] != rxWrPtr[ch*PTR_W +: PTR_W]
        && rxRdPtr[ch*PTR_W +: PTR_W] != lastRxPtrs[ch*PTR_W +: PTR_W])
      |=> irqFlags[ch] && lastRxPtrs[ch*PTR_W +: PTR_W] == $past(rxRdPtr[ch*PTR_W +: PTR_W]));

    p_tx_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
      (evalStrobe && txRdPtr[ch*PTR_W +: PTR_W] != txWrPtr[ch*PTR_W +: PTR_W])
      |=> lastTxPtrs[ch*PTR_W +: PTR_W] == 8'hFF);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
      (clearFlags[ch] && !evalStrobe) |=> !irqFlags[ch]);
  end
endmodule

bind fifo_irq_flagger fifo_irq_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .evalStrobe (evalStrobe),
  .rxRdPtr    (rxRdPtr),
  .rxWrPtr    (rxWrPtr),
  .txRdPtr    (txRdPtr),
  .txWrPtr    (txWrPtr),
  .clearFlags (clearFlags),
  .irqFlags   (irqFlags),
  .lastRxPtrs (lastRxPtrs),
  .lastTxPtrs (lastTxPtrs)
);

// File: tb/fifo_irq_flagger_tb.sv
module fifo_irq_flagger_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evalStrobe = 1'b0;
  logic [31:0] rxRdPtr = '0, rxWrPtr = '0, txRdPtr = '0, txWrPtr = '0;
  logic [3:0]  clearFlags = '0;
  logic [3:0]  irqFlags;
  logic [31:0] lastRxPtrs, lastTxPtrs;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  fifo_irq_flagger dut_i (
    .clk(clk), .rstN(rstN), .evalStrobe(evalStrobe),
    .rxRdPtr(rxRdPtr), .rxWrPtr(rxWrPtr), .txRdPtr(txRdPtr), .txWrPtr(txWrPtr),
    .clearFlags(clearFlags), .irqFlags(irqFlags),
    .lastRxPtrs(lastRxPtrs), .lastTxPtrs(lastTxPtrs)
  );

  // per-channel stimulus and reference state
  logic [7:0] sRxRd[4], sRxWr[4], sTxRd[4], sTxWr[4];
  logic [7:0] mRx[4], mTx[4];
  logic [3:0] mFlags;

  logic [3:0]  expFlagsQ[$];
  logic [31:0] expRxQ[$], expTxQ[$];
  string       tagQ[$];

  task automatic step(input bit ev, input logic [3:0] clr, input string tag);
    logic [3:0] fire;
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      rxRdPtr[c*8 +: 8] = sRxRd[c];
      rxWrPtr[c*8 +: 8] = sRxWr[c];
      txRdPtr[c*8 +: 8] = sTxRd[c];
      txWrPtr[c*8 +: 8] = sTxWr[c];
    end
    evalStrobe = ev;
    clearFlags = clr;
    fire = '0;
    if (ev) begin
      for (int c = 0; c < 4; c++) begin
        if (sRxRd[c] == sRxWr[c]) mRx[c] = 8'hFF;
        else if (sRxRd[c] != mRx[c]) begin fire[c] = 1'b1; mRx[c] = sRxRd[c]; end
        if (sTxRd[c] != sTxWr[c]) mTx[c] = 8'hFF;
        else if (sTxWr[c] != mTx[c]) begin fire[c] = 1'b1; mTx[c] = sTxWr[c]; end
      end
    end
    mFlags = (mFlags & ~clr) | fire;
    expFlagsQ.push_back(mFlags);
    expRxQ.push_back({mRx[3], mRx[2], mRx[1], mRx[0]});
    expTxQ.push_back({mTx[3], mTx[2], mTx[1], mTx[0]});
    tagQ.push_back(tag);
  endtask

  // monitor: one registered result per driven cycle
  always @(posedge clk) begin
    #2;
    if (tagQ.size() > 0) begin
      logic [3:0]  ef;
      logic [31:0] er, et;
      string       tg;
      ef = expFlagsQ.pop_front();
      er = expRxQ.pop_front();
      et = expTxQ.pop_front();
      tg = tagQ.pop_front();
      checks++;
      if (irqFlags !== ef || lastRxPtrs !== er || lastTxPtrs !== et) begin
        fails++;
        $display("FAIL %s: flags=%h rx=%h tx=%h expected flags=%h rx=%h tx=%h",
                 tg, irqFlags, lastRxPtrs, lastTxPtrs, ef, er, et);
      end
    end
  end

  task automatic setAll(input logic [7:0] rr, rw, tr, tw);
    for (int c = 0; c < 4; c++) begin
      sRxRd[c] = rr; sRxWr[c] = rw; sTxRd[c] = tr; sTxWr[c] = tw;
    end
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin mRx[c] = 8'hFF; mTx[c] = 8'hFF; end
    mFlags = '0;
    setAll(8'h00, 8'h00, 8'h01, 8'h02);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (irqFlags !== 4'h0 || lastRxPtrs !== 32'hFFFF_FFFF || lastTxPtrs !== 32'hFFFF_FFFF) begin
      fails++;
      $display("FAIL R1: flags=%h rx=%h tx=%h expected flags=0 rx=ffffffff tx=ffffffff",
               irqFlags, lastRxPtrs, lastTxPtrs);
    end

    step(1, 4'h0, "R3 R6 all idle");
    sRxRd[0] = 8'h03; sRxWr[0] = 8'h05;
    step(1, 4'h0, "R5 R2 rx ch0 fires");
    step(1, 4'h1, "R4 repeat does not refire");
    sRxRd[0] = 8'h04;
    step(1, 4'h0, "R5 rx ch0 moved");
    sTxRd[2] = 8'h07; sTxWr[2] = 8'h07;
    step(1, 4'h1, "R7 R2 tx ch2 drained");
    step(1, 4'h4, "R7 equal does not refire");
    sRxRd[1] = 8'hFF; sRxWr[1] = 8'h10;
    step(1, 4'h0, "R10 pointer FF versus sentinel");
    sRxRd[3] = 8'h20; sRxWr[3] = 8'h22; sTxRd[3] = 8'h09; sTxWr[3] = 8'h09;
    step(1, 4'h0, "R8 rx and tx same channel");
    sRxRd[2] = 8'h30; sRxWr[2] = 8'h31;
    step(1, 4'hF, "R9 fire overrides clear");
    sRxRd[0] = 8'h50; sTxWr[2] = 8'h60; sTxRd[2] = 8'h60;
    step(0, 4'h0, "R11 no strobe holds");
    step(0, 4'h4, "R9 clear without strobe");
    sRxRd[0] = 8'h05;
    step(1, 4'h0, "R3 rx ch0 empties");
    sTxRd[3] = 8'h0A;
    step(1, 4'h0, "R6 tx ch3 busy");
    for (int i = 0; i < 200; i++) begin
      for (int c = 0; c < 4; c++) begin
        sRxRd[c] = 8'($urandom_range(0, 3)); sRxWr[c] = 8'($urandom_range(0, 3));
        sTxRd[c] = 8'($urandom_range(0, 3)); sTxWr[c] = 8'($urandom_range(0, 3));
      end
      step(($urandom_range(0, 3) != 0), 4'($urandom_range(0, 15)), "R2 R3 R4 R5 R6 R7 R9 R11 mixed");
    end
    @(negedge clk);
    evalStrobe = 1'b0; clearFlags = '0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule